// File: doc/BRIEF.md
# Playback Status and Indicator Port Driver

This block turns the playback state of a voice engine into the levels of four general-purpose output ports. It watches three inputs from the engine: a busy level, a one-cycle end-of-playback pulse and a sample-rate tick. Each port can be set up as a status output that follows the engine state. Ports A, B and C can also be set up as an indicator output that drives an LED with a flashing, duty-pattern or steady level.

Each port decodes its own fixed menu of modes. Every status and LED option has a defined idle level. Until the engine reports its first playback after reset, every port drives a level chosen per port by the integrator. All pattern timing counts sample ticks, never clock cycles. The pattern counters sit at zero while the engine is idle, so every playback starts its pattern from the first phase.

Top module: `play_status_ports`

## Requirements
- R1: From reset until the first clock edge at which `busy_i` is sampled high, `port_o[p]` equals `init_lvl_i[p]` for every port. This holds whatever the mode inputs and `done_i` do.
- R2: Once started, a port in busy-high status shows the `busy_i` value sampled at the last clock edge, and a port in busy-low status shows its inverse. Busy-high is status option 0 on ports A, B and C, and option 0 of set 0 on port D. Busy-low is option 2 on port C and option 0 of set 1 on port D.
- R3: Once started, steady-low status stays low and steady-high status stays high. Steady-low is option 1 on ports A, B and C and option 1 of set 0 on port D. Steady-high is option 3 on ports A, B and C and option 1 of set 1 on port D.
- R4: Status option 2 on ports A and B is stop-high. The port goes high after an edge that samples `done_i` high, and it stays high until STOP_TICKS further ticks are sampled, then drops low. A new `done_i` restarts the count, and a tick sampled together with `done_i` is not counted.
- R5: An LED-mode port (`led_en_i[p]`=1, p=0..2) drives high whenever `busy_i` was sampled low at the last edge.
- R6: While busy, let E be the number of ticks sampled during the current busy period. LED option 0 is a fast flash. On ports A and C it is high when E mod FAST_TICKS < FAST_TICKS/2. On port B it is the inverse.
- R7: LED option 1 is a slow flash, defined the same way with SLOW_TICKS. It is positive on ports A and C and inverted on port B.
- R8: LED option 2 on ports A and B is a ten-slot pattern. The slot number is floor(E/SLOT_TICKS) mod 10. The port is high in slots 0 to 6 on port A and in slots 0 to 8 on port B.
- R9: While busy, steady LED options drive a fixed level. Port A option 3 drives low. Port B option 3 drives high. Port C option 2 drives high and option 3 drives low.
- R10: Port D has no LED mode. `led_en_i[3]` selects its status set and only `opt_i[6]` picks the option. `opt_i[7]` has no effect on the port.
- R11: E restarts from zero whenever `busy_i` is sampled low, so each new busy period starts its pattern at phase zero.
- R12: Port p takes its option from `opt_i[2p+1:2p]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Engine is playing |
| done_i | input | 1 | One-cycle pulse at end of playback |
| tick_i | input | 1 | Sample-rate enable |
| led_en_i | input | 4 | Per-port LED mode enable; bit 3 selects port D status set |
| opt_i | input | 8 | Two-bit option per port, port p at bits 2p+1:2p |
| init_lvl_i | input | 4 | Level of each port before the first playback |
| port_o | output | 4 | Port levels, bit 0 = port A ... bit 3 = port D |

## Verification
The bench sweeps every option value and every LED/status enable combination, with a reset before each one, and each port has its own initial level. This catches a design that lets the initial level leak past the first playback or releases it too early. Uneven tick patterns expose flash and slot counters that count clock cycles instead of ticks, and slot patterns that wrap at the wrong slot. A second busy period follows a short idle gap, which catches counters that keep their phase across idle time. A stop pulse that is one tick too long or too short, or one where a tick and end-of-playback in the same cycle count wrongly, is also caught. Driving `opt_i[7]` with port D's option bit set and clear shows whether a design wrongly decodes that bit.

// File: rtl/psd_pkg.sv
package psd_pkg;

   localparam int NUM_PORTS  = 4;
   localparam int SLOTS_PER_FRAME = 10;
   localparam int DYN_A_ACTIVE = 7;
   localparam int DYN_B_ACTIVE = 9;

   typedef struct packed {
      logic busy;
      logic fast;
      logic slow;
      logic dyn_a;
      logic dyn_b;
      logic stop;
   } psd_sig_t;

endpackage

// File: rtl/psd_timebase.sv
module psd_timebase #(
   parameter int FAST_TICKS = 256,
   parameter int SLOW_TICKS = 1024,
   parameter int SLOT_TICKS = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy_i,
   input  logic tick_i,
   output logic fast_o,
   output logic slow_o,
   output logic dyn_a_o,
   output logic dyn_b_o
);
   import psd_pkg::*;

   localparam int PW  = $clog2(SLOW_TICKS);
   localparam int FB  = $clog2(FAST_TICKS) - 1;
   localparam int SB  = PW - 1;
   localparam int IW  = $clog2(SLOTS_PER_FRAME);

   generate
      if (FAST_TICKS < 2 || (FAST_TICKS & (FAST_TICKS - 1)) != 0)
         $error("FAST_TICKS must be a power of two of at least 2");
      if (SLOW_TICKS < FAST_TICKS || (SLOW_TICKS & (SLOW_TICKS - 1)) != 0)
         $error("SLOW_TICKS must be a power of two not below FAST_TICKS");
      if (SLOT_TICKS < 1)
         $error("SLOT_TICKS must be positive");
   endgenerate

   logic [PW-1:0] phase_q;
   logic [IW-1:0] slot_q;
   logic          slot_adv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase_q <= '0;
      else if (!busy_i) phase_q <= '0;
      else if (tick_i)  phase_q <= phase_q + 1'b1;
   end

   generate
      if (SLOT_TICKS == 1) begin : g_slot_direct
         assign slot_adv = tick_i;
      end else begin : g_slot_div
         localparam int DW = $clog2(SLOT_TICKS);
         logic [DW-1:0] sub_q;
         assign slot_adv = tick_i && (sub_q == DW'(SLOT_TICKS - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        sub_q <= '0;
            else if (!busy_i)  sub_q <= '0;
            else if (slot_adv) sub_q <= '0;
            else if (tick_i)   sub_q <= sub_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        slot_q <= '0;
      else if (!busy_i)  slot_q <= '0;
      else if (slot_adv) slot_q <= (slot_q == IW'(SLOTS_PER_FRAME - 1)) ? '0 : slot_q + 1'b1;
   end

   assign fast_o  = ~phase_q[FB];
   assign slow_o  = ~phase_q[SB];
   assign dyn_a_o = slot_q < IW'(DYN_A_ACTIVE);
   assign dyn_b_o = slot_q < IW'(DYN_B_ACTIVE);

endmodule

// File: rtl/psd_stop_pulse.sv
module psd_stop_pulse #(
   parameter int STOP_TICKS = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic done_i,
   input  logic tick_i,
   output logic stop_o
);
   localparam int CW = $clog2(STOP_TICKS + 1);

   generate
      if (STOP_TICKS < 1) $error("STOP_TICKS must be positive");
   endgenerate

   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      left_q <= '0;
      else if (done_i)                 left_q <= CW'(STOP_TICKS);
      else if (tick_i && left_q != '0) left_q <= left_q - 1'b1;
   end

   assign stop_o = (left_q != '0);

endmodule

// File: rtl/psd_port_mux.sv
module psd_port_mux #(
   parameter int PORT = 0
) (
   input  logic              led_en_i,
   input  logic [1:0]        opt_i,
   input  psd_pkg::psd_sig_t sig_i,
   output logic              lvl_o
);
   generate
      if (PORT < 0 || PORT > 3) $error("PORT must be 0..3");

      if (PORT == 0) begin : g_a
         always_comb begin
            if (led_en_i) begin
               if (!sig_i.busy) lvl_o = 1'b1;
               else begin
                  unique case (opt_i)
                     2'd0:    lvl_o = sig_i.fast;
                     2'd1:    lvl_o = sig_i.slow;
                     2'd2:    lvl_o = sig_i.dyn_a;
                     default: lvl_o = 1'b0;
                  endcase
               end
            end else begin
               unique case (opt_i)
                  2'd0:    lvl_o = sig_i.busy;
                  2'd1:    lvl_o = 1'b0;
                  2'd2:    lvl_o = sig_i.stop;
                  default: lvl_o = 1'b1;
               endcase
            end
         end
      end else if (PORT == 1) begin : g_b
         always_comb begin
            if (led_en_i) begin
               if (!sig_i.busy) lvl_o = 1'b1;
               else begin
                  unique case (opt_i)
                     2'd0:    lvl_o = ~sig_i.fast;
                     2'd1:    lvl_o = ~sig_i.slow;
                     2'd2:    lvl_o = sig_i.dyn_b;
                     default: lvl_o = 1'b1;
                  endcase
               end
            end else begin
               unique case (opt_i)
                  2'd0:    lvl_o = sig_i.busy;
                  2'd1:    lvl_o = 1'b0;
                  2'd2:    lvl_o = sig_i.stop;
                  default: lvl_o = 1'b1;
               endcase
            end
         end
      end else if (PORT == 2) begin : g_c
         always_comb begin
            if (led_en_i) begin
               if (!sig_i.busy) lvl_o = 1'b1;
               else begin
                  unique case (opt_i)
                     2'd0:    lvl_o = sig_i.fast;
                     2'd1:    lvl_o = sig_i.slow;
                     2'd2:    lvl_o = 1'b1;
                     default: lvl_o = 1'b0;
                  endcase
               end
            end else begin
               unique case (opt_i)
                  2'd0:    lvl_o = sig_i.busy;
                  2'd1:    lvl_o = 1'b0;
                  2'd2:    lvl_o = ~sig_i.busy;
                  default: lvl_o = 1'b1;
               endcase
            end
         end
      end else begin : g_d
         always_comb begin
            unique case ({led_en_i, opt_i[0]})
               2'b00:   lvl_o = sig_i.busy;
               2'b01:   lvl_o = 1'b0;
               2'b10:   lvl_o = ~sig_i.busy;
               default: lvl_o = 1'b1;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/play_status_ports.sv
module play_status_ports #(
   parameter int FAST_TICKS = 256,
   parameter int SLOW_TICKS = 1024,
   parameter int SLOT_TICKS = 32,
   parameter int STOP_TICKS = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       busy_i,
   input  logic       done_i,
   input  logic       tick_i,
   input  logic [3:0] led_en_i,
   input  logic [7:0] opt_i,
   input  logic [3:0] init_lvl_i,
   output logic [3:0] port_o
);
   import psd_pkg::*;

   logic     busy_q;
   logic     started_q;
   psd_sig_t sig;
   logic [NUM_PORTS-1:0] mux_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         started_q <= 1'b0;
      end else begin
         busy_q <= busy_i;
         if (busy_i) started_q <= 1'b1;
      end
   end

   psd_timebase #(
      .FAST_TICKS(FAST_TICKS),
      .SLOW_TICKS(SLOW_TICKS),
      .SLOT_TICKS(SLOT_TICKS)
   ) u_time (
      .clk    (clk),
      .rst_n  (rst_n),
      .busy_i (busy_i),
      .tick_i (tick_i),
      .fast_o (sig.fast),
      .slow_o (sig.slow),
      .dyn_a_o(sig.dyn_a),
      .dyn_b_o(sig.dyn_b)
   );

   psd_stop_pulse #(.STOP_TICKS(STOP_TICKS)) u_stop (
      .clk   (clk),
      .rst_n (rst_n),
      .done_i(done_i),
      .tick_i(tick_i),
      .stop_o(sig.stop)
   );

   assign sig.busy = busy_q;

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         psd_port_mux #(.PORT(p)) u_mux (
            .led_en_i(led_en_i[p]),
            .opt_i   (opt_i[2*p +: 2]),
            .sig_i   (sig),
            .lvl_o   (mux_lvl[p])
         );
      end
   endgenerate

   assign port_o = started_q ? mux_lvl : init_lvl_i;

endmodule

// File: rtl/psd_checker.sv
module psd_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       busy_i,
   input logic       done_i,
   input logic [3:0] led_en_i,
   input logic [7:0] opt_i,
   input logic [3:0] init_lvl_i,
   input logic [3:0] port_o
);
   logic seen, busy_d, done_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen   <= 1'b0;
         busy_d <= 1'b0;
         done_d <= 1'b0;
      end else begin
         if (busy_i) seen <= 1'b1;
         busy_d <= busy_i;
         done_d <= done_i;
      end
   end

   assert_init_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !seen |-> port_o == init_lvl_i);

   assert_busy_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && !led_en_i[0] && opt_i[1:0] == 2'd0) |-> port_o[0] == busy_d);

   assert_steady_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && !led_en_i[2] && opt_i[5:4] == 2'd3) |-> port_o[2]);

   assert_stop_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && done_d && !led_en_i[0] && opt_i[1:0] == 2'd2) |-> port_o[0]);

   assert_led_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && led_en_i[1] && !busy_d) |-> port_o[1]);

   assert_led_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && led_en_i[1] && busy_d && opt_i[3:2] == 2'd3) |-> port_o[1]);

   assert_d_set1_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && led_en_i[3] && opt_i[6]) |-> port_o[3]);

endmodule

bind play_status_ports psd_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy_i    (busy_i),
   .done_i    (done_i),
   .led_en_i  (led_en_i),
   .opt_i     (opt_i),
   .init_lvl_i(init_lvl_i),
   .port_o    (port_o)
);

// File: tb/play_status_ports_test.sv
module play_status_ports_test;
   localparam int F  = 4;
   localparam int S  = 8;
   localparam int SL = 2;
   localparam int ST = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       busy_i = 1'b0, done_i = 1'b0, tick_i = 1'b0;
   logic [3:0] led_en_i = '0;
   logic [7:0] opt_i = '0;
   logic [3:0] init_lvl_i = '0;
   logic [3:0] port_o;

   int checks = 0, failures = 0;
   bit restart_phase = 0;

   int m_e = 0, m_rem = 0;
   bit m_busy = 0, m_started = 0;

   always #5 clk = ~clk;

   play_status_ports #(.FAST_TICKS(F), .SLOW_TICKS(S), .SLOT_TICKS(SL), .STOP_TICKS(ST)) uut (
      .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .done_i(done_i), .tick_i(tick_i),
      .led_en_i(led_en_i), .opt_i(opt_i), .init_lvl_i(init_lvl_i), .port_o(port_o));

   function automatic bit expect_lvl(int p, output string tag);
      bit fast = (m_e % F) < (F / 2);
      bit slow = (m_e % S) < (S / 2);
      int slot = (m_e / SL) % 10;
      bit led = led_en_i[p];
      int o = (p == 3) ? int'(opt_i[6]) : int'(opt_i[2*p +: 2]);
      tag = "R12";
      if (!m_started) begin tag = "R1"; return init_lvl_i[p]; end
      if (p == 3) begin
         tag = "R10";
         case ({led, o[0]})
            2'b00: return m_busy;
            2'b01: return 1'b0;
            2'b10: return !m_busy;
            default: return 1'b1;
         endcase
      end
      if (led) begin
         if (!m_busy) begin tag = "R5"; return 1'b1; end
         tag = (o == 0) ? "R6" : (o == 1) ? "R7" : (o == 2 && p != 2) ? "R8" : "R9";
         if (restart_phase && tag != "R9") tag = "R11";
         case (o)
            0: return (p == 1) ? !fast : fast;
            1: return (p == 1) ? !slow : slow;
            2: return (p == 0) ? (slot < 7) : (p == 1) ? (slot < 9) : 1'b1;
            default: return (p == 1);
         endcase
      end
      case (o)
         0: begin tag = "R2"; return m_busy; end
         1: begin tag = "R3"; return 1'b0; end
         2: if (p == 2) begin tag = "R2"; return !m_busy; end
            else begin tag = "R4"; return m_rem > 0; end
         default: begin tag = "R3"; return 1'b1; end
      endcase
   endfunction

   task automatic check_all();
      for (int p = 0; p < 4; p++) begin
         string tag;
         bit e = expect_lvl(p, tag);
         checks++;
         if (port_o[p] !== e) begin
            failures++;
            $display("FAIL %s port %0d led=%b opt=%h actual=%b expected=%b", tag, p,
                     led_en_i, opt_i, port_o[p], e);
         end
      end
   endtask

   task automatic cyc(bit b, bit t, bit d);
      busy_i = b; tick_i = t; done_i = d;
      @(posedge clk);
      if (!rst_n) begin
         m_e = 0; m_rem = 0; m_busy = 0; m_started = 0;
      end else begin
         if (busy_i) m_started = 1;
         if (!busy_i) m_e = 0;
         else if (tick_i) m_e++;
         m_busy = busy_i;
         if (done_i) m_rem = ST;
         else if (tick_i && m_rem > 0) m_rem--;
      end
      @(negedge clk);
      check_all();
   endtask

   initial begin
      for (int cfg = 0; cfg < 64; cfg++) begin
         bit [1:0] v = cfg[5:4];
         @(negedge clk);
         rst_n = 1'b0;
         led_en_i = cfg[3:0];
         opt_i = {4{v}};
         init_lvl_i = cfg[3:0] ^ 4'(cfg >> 2) ^ 4'b0110;
         cyc(0, 0, 0);
         cyc(0, 1, 0);
         rst_n = 1'b1;
         // R1: idle with an end-of-play pulse keeps the initial levels
         cyc(0, 1, 0);
         cyc(0, 0, 1);
         cyc(0, 1, 0);
         // first busy period with an uneven tick pattern
         for (int i = 0; i < 44; i++) cyc(1, (i % 3) != 2, (i == 20));
         // end of playback: stop pulse (R4) and LED idle level (R5)
         cyc(0, 1, 1);
         for (int i = 0; i < 7; i++) cyc(0, (i % 2) == 0, 0);
         // R4: tick sampled together with a new done is not counted
         cyc(0, 1, 1);
         for (int i = 0; i < 4; i++) cyc(0, 1, 0);
         // R11: second busy period restarts at phase zero
         restart_phase = 1;
         for (int i = 0; i < 12; i++) cyc(1, 1, 0);
         restart_phase = 0;
         cyc(0, 1, 0);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule